// File: doc/BRIEF.md
# Graphics Command Packet Framer

The framer sits between a source of 32-bit command words (a FIFO or a DMA engine) and a drawing back end. It reads the opcode from the top byte of the first word of each packet and works out how many words the packet holds from a per-opcode length rule. It gathers those words in a local buffer and offers the complete packet to the back end over a valid/ready interface. The input is stalled while a finished packet waits for the back end.

Some opcode groups are handled differently. Polyline opcodes have no fixed length, so they run until a terminator vertex arrives. A polyline longer than the buffer leaves in chunks that carry a continuation flag. Image-transfer opcodes are not sent to the back end. Their position and size words go to a separate transfer unit. For a host-to-memory transfer, the pixel words that follow go straight to that unit and are not decoded as commands. Environment opcodes are written into an eight-entry register bank, and they also pass to the back end as one-word packets.

Top module: `gfx_cmd_framer`

## Requirements
- R1: A packet whose opcode `op = word[31:24]` is outside the polyline, image and environment groups holds 1 + extra words, and the packet is offered whole. The extra count is: 0x02 → 2; 0x20–23 → 3, 24–27 → 6, 28–2B → 4, 2C–2F → 8, 30–33 → 5, 34–37 → 8, 38–3B → 7, 3C–3F → 11; 0x40–47 → 2; 0x50–57 → 3; 0x60–63 → 2, 64–67 → 3, 68–6B → 1, 6C–6F → 0, 70–73 → 1, 74–77 → 2, 78–7B → 1, 7C–7F → 2; 0x80 → 3.
- R2: Every other opcode outside the special groups (for example 0x00, 0x1F, 0x90, 0xE8) is offered as a one-word packet.
- R3: Unshaded polylines are opcodes 0x48–0x4F. The framer tests every packet word from index 3 onward, counting the opcode word as index 0. The packet ends with, and includes, the first tested word for which `(w & 0xF000F000) == 0x50005000`. A matching word at index 1 or 2 does not end the packet.
- R4: Shaded polylines are opcodes 0x58–0x5F. The framer tests only the even packet indices 4, 6, 8 and onward. A matching word at an odd index is kept as data.
- R5: A polyline that reaches BUF_WORDS words without a terminator is offered as a chunk with `pkt_more=1` and `pkt_len=BUF_WORDS`. Collection then goes on with the packet index still counting, so the even/odd rule of R4 holds across chunks. The final chunk has `pkt_more=0`.
- R6: Opcodes 0xA0–0xDF take exactly three words and produce no packet. One cycle after the third word is accepted, `xfer_valid` pulses for one cycle with `xfer_pos` set to word 1 and `xfer_size` set to word 2. `xfer_read` is 1 when `op[7:5]==3'b110`.
- R7: After a write transfer, the next ceil(w·h/2) accepted words go to `pix_data`, with `pix_valid` high one cycle after each word is accepted. Here w = ((size[9:0]−1) mod 1024)+1 and h = ((size[24:16]−1) mod 512)+1. These words are never decoded as commands, and decoding resumes with the word after them. A read transfer does not divert any words.
- R8: An opcode 0xE0–0xE7 writes the whole word into environment register `op[2:0]`. The new value is visible on `env_regs[32*i +: 32]` one cycle after the word is accepted, and the word is also offered as a one-word packet.
- R9: After reset, environment register i holds `(0xE0+i)<<24`, and `in_ready` is 1 while `pkt_valid`, `xfer_valid` and `pix_valid` are 0.
- R10: While `pkt_valid` is 1 and `pkt_ready` is 0, `in_ready` is 0 and the packet outputs hold their values. An incomplete packet is never offered.
- R11: `pkt_valid` rises in the cycle after the last word of a packet or chunk is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Command word offered |
| in_data | input | 32 | Command word |
| in_ready | output | 1 | Word accepted when high together with in_valid |
| pkt_valid | output | 1 | Packet or chunk available |
| pkt_ready | input | 1 | Back end takes the packet |
| pkt_len | output | LEN_W | Number of valid words in pkt_words |
| pkt_more | output | 1 | Chunk of a polyline that continues |
| pkt_words | output | 32·BUF_WORDS | Packet words, word k at [32k +: 32] |
| xfer_valid | output | 1 | One-cycle transfer start pulse |
| xfer_read | output | 1 | Transfer direction is memory to host |
| xfer_pos | output | 32 | Position word of the transfer |
| xfer_size | output | 32 | Size word of the transfer |
| pix_valid | output | 1 | Pixel word strobe |
| pix_data | output | 32 | Pixel word for a write transfer |
| env_regs | output | 32·N_ENV | Environment register bank, entry i at [32i +: 32] |

## Verification
Every result of the framer is registered. The packet, the transfer pulse, each pixel strobe and each environment write appear exactly one cycle after the input word that causes them is accepted. The bench drives a word, waits for the accepting edge, and samples one time unit later. It then expects the result to be present, and to have been absent before that last word. For backpressure, the bench holds a word at the input across several edges with the back end not ready. It checks that `in_ready` stays low and the packet is unchanged, and that the held word is taken at the edge after the pop.

// File: rtl/gfx_cmd_pkg.sv
package gfx_cmd_pkg;

  // Extra words after the opcode word for regular opcodes.
  function automatic logic [3:0] extra_words(input logic [7:0] op);
    logic [3:0] n;
    n = 4'd0;
    case (op[7:5])
      3'b000: n = (op == 8'h02) ? 4'd2 : 4'd0;
      3'b001: begin
        case (op[4:2])
          3'd0: n = 4'd3;
          3'd1: n = 4'd6;
          3'd2: n = 4'd4;
          3'd3: n = 4'd8;
          3'd4: n = 4'd5;
          3'd5: n = 4'd8;
          3'd6: n = 4'd7;
          default: n = 4'd11;
        endcase
      end
      3'b010: n = op[4] ? (op[3] ? 4'd4 : 4'd3) : (op[3] ? 4'd3 : 4'd2);
      3'b011: begin
        case (op[4:2])
          3'd0: n = 4'd2;
          3'd1: n = 4'd3;
          3'd2: n = 4'd1;
          3'd3: n = 4'd0;
          3'd4: n = 4'd1;
          3'd5: n = 4'd2;
          3'd6: n = 4'd1;
          default: n = 4'd2;
        endcase
      end
      3'b100: n = (op == 8'h80) ? 4'd3 : 4'd0;
      default: n = 4'd0;
    endcase
    return n;
  endfunction

  function automatic logic is_poly_op(input logic [7:0] op);
    return (op[7:5] == 3'b010) && op[3];
  endfunction

  function automatic logic is_img_op(input logic [7:0] op);
    return (op >= 8'hA0) && (op <= 8'hDF);
  endfunction

  function automatic logic is_env_op(input logic [7:0] op);
    return op[7:3] == 5'b11100;
  endfunction

  function automatic logic is_term_word(input logic [31:0] w);
    return (w & 32'hF000_F000) == 32'h5000_5000;
  endfunction

  // Packet index folded so that 4,5 repeat: keeps "past start" and parity.
  function automatic logic [2:0] next_pidx(input logic [2:0] i);
    return (i == 3'd5) ? 3'd4 : i + 3'd1;
  endfunction

  function automatic logic term_slot(input logic [2:0] i, input logic shaded);
    return shaded ? ((i >= 3'd4) && !i[0]) : (i >= 3'd3);
  endfunction

  // Pixel words in a write transfer: ceil(w*h/2), zero fields mean maximum.
  function automatic logic [19:0] pix_words(input logic [31:0] size);
    logic [10:0] w;
    logic [9:0]  h;
    logic [20:0] p;
    w = {1'b0, size[9:0] - 10'd1} + 11'd1;
    h = {1'b0, size[24:16] - 9'd1} + 10'd1;
    p = 21'(w) * 21'(h);
    return 20'((p + 21'd1) >> 1);
  endfunction

endpackage

// File: rtl/gfx_cmd_env_bank.sv
module gfx_cmd_env_bank #(
  parameter int N_ENV = 8,
  parameter int SEL_W = $clog2(N_ENV)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [SEL_W-1:0]    wr_sel,
  input  logic [31:0]         wr_word,
  output logic [32*N_ENV-1:0] regs_flat
);

  logic [31:0] env_q [N_ENV];

  for (genvar g = 0; g < N_ENV; g++) begin : g_env
    always_ff @(posedge clk) begin
      if (!rst_n)
        env_q[g] <= {8'(8'hE0 + g), 24'h0};
      else if (wr_en && (wr_sel == SEL_W'(g)))
        env_q[g] <= wr_word;
    end
    assign regs_flat[32*g +: 32] = env_q[g];
  end

endmodule

// File: rtl/gfx_cmd_pix_path.sv
module gfx_cmd_pix_path import gfx_cmd_pkg::*; #(
  parameter int CNT_W = 20
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [31:0] start_pos,
  input  logic [31:0] start_size,
  input  logic        start_read,
  input  logic        pix_fire,
  input  logic [31:0] pix_word,
  output logic        busy,
  output logic        xfer_valid,
  output logic        xfer_read,
  output logic [31:0] xfer_pos,
  output logic [31:0] xfer_size,
  output logic        pix_valid,
  output logic [31:0] pix_data
);

  logic [CNT_W-1:0] remain_q;
  logic             last_pix;

  assign busy     = (remain_q != '0);
  assign last_pix = pix_fire && (remain_q == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remain_q   <= '0;
      xfer_valid <= 1'b0;
      xfer_read  <= 1'b0;
      xfer_pos   <= '0;
      xfer_size  <= '0;
      pix_valid  <= 1'b0;
      pix_data   <= '0;
    end else begin
      xfer_valid <= start;
      pix_valid  <= pix_fire;
      if (pix_fire) begin
        pix_data <= pix_word;
        remain_q <= remain_q - CNT_W'(1);
      end
      if (start) begin
        xfer_read <= start_read;
        xfer_pos  <= start_pos;
        xfer_size <= start_size;
        if (!start_read) remain_q <= CNT_W'(pix_words(start_size));
      end
    end
  end

  assert_xfer_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid |=> !xfer_valid);

  assert_pix_only_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pix_fire |-> busy);

  assert_pix_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    last_pix && !start |=> !busy);

endmodule

// File: rtl/gfx_cmd_collect.sv
module gfx_cmd_collect import gfx_cmd_pkg::*; #(
  parameter int BUF_WORDS = 16,
  parameter int LEN_W     = $clog2(BUF_WORDS + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    fire,
  input  logic [31:0]             word,
  input  logic                    pkt_ready,
  output logic                    pkt_valid,
  output logic [LEN_W-1:0]        pkt_len,
  output logic                    pkt_more,
  output logic [32*BUF_WORDS-1:0] pkt_words,
  output logic                    img_go,
  output logic [31:0]             img_pos,
  output logic [31:0]             img_size,
  output logic                    img_read,
  output logic                    env_wr,
  output logic [2:0]              env_sel
);

  localparam int IDX_W = $clog2(BUF_WORDS);

  logic [31:0]      buf_q [BUF_WORDS];
  logic [LEN_W-1:0] fill_q, need_q;
  logic             poly_q, shaded_q, img_q;
  logic [2:0]       pidx_q;

  logic [7:0]       op;
  logic             first;
  logic [LEN_W-1:0] cur_need, fill_n;
  logic             cur_poly, cur_shaded, cur_img;
  logic [2:0]       cur_pidx;
  logic             term_hit, done_fixed, chunk_full, issue;

  assign op         = word[31:24];
  assign first      = (fill_q == '0) && !poly_q;
  assign cur_poly   = first ? is_poly_op(op) : poly_q;
  assign cur_shaded = first ? op[4] : shaded_q;
  assign cur_img    = first ? is_img_op(op) : img_q;
  assign cur_need   = first ? (is_img_op(op) ? LEN_W'(3) : LEN_W'(extra_words(op)) + LEN_W'(1))
                            : need_q;
  assign cur_pidx   = first ? 3'd0 : pidx_q;
  assign fill_n     = fill_q + LEN_W'(1);
  assign term_hit   = cur_poly && term_slot(cur_pidx, cur_shaded) && is_term_word(word);
  assign done_fixed = !cur_poly && (fill_n == cur_need);
  assign chunk_full = cur_poly && !term_hit && (fill_n == LEN_W'(BUF_WORDS));
  assign issue      = fire && (term_hit || chunk_full || (done_fixed && !cur_img));

  assign img_go   = fire && done_fixed && cur_img;
  assign img_pos  = buf_q[1];
  assign img_size = word;
  assign img_read = (buf_q[0][31:29] == 3'b110);

  assign env_wr  = fire && first && is_env_op(op);
  assign env_sel = op[2:0];

  always_ff @(posedge clk) begin
    if (fire) buf_q[fill_q[IDX_W-1:0]] <= word;
  end

  for (genvar g = 0; g < BUF_WORDS; g++) begin : g_out
    assign pkt_words[32*g +: 32] = buf_q[g];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill_q    <= '0;
      need_q    <= '0;
      poly_q    <= 1'b0;
      shaded_q  <= 1'b0;
      img_q     <= 1'b0;
      pidx_q    <= 3'd0;
      pkt_valid <= 1'b0;
      pkt_len   <= '0;
      pkt_more  <= 1'b0;
    end else begin
      if (pkt_valid && pkt_ready) pkt_valid <= 1'b0;
      if (fire) begin
        pidx_q   <= next_pidx(cur_pidx);
        need_q   <= cur_need;
        shaded_q <= cur_shaded;
        if (issue) begin
          pkt_valid <= 1'b1;
          pkt_len   <= fill_n;
          pkt_more  <= chunk_full;
          fill_q    <= '0;
          poly_q    <= chunk_full;
          img_q     <= 1'b0;
        end else if (img_go) begin
          fill_q <= '0;
          poly_q <= 1'b0;
          img_q  <= 1'b0;
        end else begin
          fill_q <= fill_n;
          poly_q <= cur_poly;
          img_q  <= cur_img;
        end
      end
    end
  end

  assert_pkt_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid && !pkt_ready |=> pkt_valid && $stable(pkt_len) && $stable(pkt_more));

  assert_no_accept_pending_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |-> !fire);

  assert_len_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |-> (pkt_len != '0) && (pkt_len <= LEN_W'(BUF_WORDS)));

  assert_chunk_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid && pkt_more |-> pkt_len == LEN_W'(BUF_WORDS));

  assert_rise_after_word_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pkt_valid) |-> $past(fire));

endmodule

// File: rtl/gfx_cmd_framer.sv
module gfx_cmd_framer import gfx_cmd_pkg::*; #(
  parameter int BUF_WORDS = 16,
  parameter int N_ENV     = 8,
  parameter int LEN_W     = $clog2(BUF_WORDS + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [31:0]             in_data,
  output logic                    in_ready,
  output logic                    pkt_valid,
  input  logic                    pkt_ready,
  output logic [LEN_W-1:0]        pkt_len,
  output logic                    pkt_more,
  output logic [32*BUF_WORDS-1:0] pkt_words,
  output logic                    xfer_valid,
  output logic                    xfer_read,
  output logic [31:0]             xfer_pos,
  output logic [31:0]             xfer_size,
  output logic                    pix_valid,
  output logic [31:0]             pix_data,
  output logic [32*N_ENV-1:0]     env_regs
);

  localparam int SEL_W = $clog2(N_ENV);

  logic        busy, fire, col_fire, pix_fire;
  logic        img_go, img_read, env_wr;
  logic [31:0] img_pos, img_size;
  logic [2:0]  env_sel;

  assign in_ready = busy ? 1'b1 : !pkt_valid;
  assign fire     = in_valid && in_ready;
  assign col_fire = fire && !busy;
  assign pix_fire = fire && busy;

  gfx_cmd_collect #(.BUF_WORDS(BUF_WORDS), .LEN_W(LEN_W)) u_collect (
    .clk(clk), .rst_n(rst_n), .fire(col_fire), .word(in_data),
    .pkt_ready(pkt_ready), .pkt_valid(pkt_valid), .pkt_len(pkt_len),
    .pkt_more(pkt_more), .pkt_words(pkt_words),
    .img_go(img_go), .img_pos(img_pos), .img_size(img_size), .img_read(img_read),
    .env_wr(env_wr), .env_sel(env_sel)
  );

  gfx_cmd_pix_path #(.CNT_W(20)) u_pix (
    .clk(clk), .rst_n(rst_n), .start(img_go), .start_pos(img_pos),
    .start_size(img_size), .start_read(img_read),
    .pix_fire(pix_fire), .pix_word(in_data), .busy(busy),
    .xfer_valid(xfer_valid), .xfer_read(xfer_read), .xfer_pos(xfer_pos),
    .xfer_size(xfer_size), .pix_valid(pix_valid), .pix_data(pix_data)
  );

  gfx_cmd_env_bank #(.N_ENV(N_ENV), .SEL_W(SEL_W)) u_env (
    .clk(clk), .rst_n(rst_n), .wr_en(env_wr), .wr_sel(SEL_W'(env_sel)),
    .wr_word(in_data), .regs_flat(env_regs)
  );

  assert_in_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid && !busy |-> !in_ready);

  assert_no_pkt_in_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !pkt_valid);

  assert_pix_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |-> !xfer_valid);

endmodule

// File: tb/test_gfx_cmd_framer.sv
module test_gfx_cmd_framer;
  localparam int BUF_WORDS = 16;
  localparam int N_ENV     = 8;
  localparam int LEN_W     = $clog2(BUF_WORDS + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic in_ready, pkt_valid, pkt_more, xfer_valid, xfer_read, pix_valid;
  logic pkt_ready = 1'b0;
  logic [LEN_W-1:0] pkt_len;
  logic [32*BUF_WORDS-1:0] pkt_words;
  logic [31:0] xfer_pos, xfer_size, pix_data;
  logic [32*N_ENV-1:0] env_regs;

  int total = 0;
  int fails = 0;

  always #5 clk = ~clk;

  gfx_cmd_framer #(.BUF_WORDS(BUF_WORDS), .N_ENV(N_ENV)) i_gfx_cmd_framer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .pkt_valid(pkt_valid), .pkt_ready(pkt_ready),
    .pkt_len(pkt_len), .pkt_more(pkt_more), .pkt_words(pkt_words),
    .xfer_valid(xfer_valid), .xfer_read(xfer_read), .xfer_pos(xfer_pos),
    .xfer_size(xfer_size), .pix_valid(pix_valid), .pix_data(pix_data),
    .env_regs(env_regs)
  );

  // {opcode, expected total length}
  localparam logic [15:0] VEC [24] = '{
    16'h00_01, 16'h02_03, 16'h1F_01, 16'h20_04, 16'h25_07, 16'h2A_05,
    16'h2F_09, 16'h31_06, 16'h36_09, 16'h3B_08, 16'h3C_0C, 16'h42_03,
    16'h53_04, 16'h61_03, 16'h66_04, 16'h6A_02, 16'h6D_01, 16'h72_02,
    16'h76_03, 16'h79_02, 16'h7E_03, 16'h80_04, 16'h90_01, 16'hE8_01
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(input logic [31:0] w);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = w;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic pop();
    @(negedge clk);
    pkt_ready = 1'b1;
    @(posedge clk);
    #1;
    pkt_ready = 1'b0;
  endtask

  function automatic logic [31:0] pw(input int k);
    return pkt_words[32*k +: 32];
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R9 reset state
    chk("R9 in_ready", 64'(in_ready), 64'd1);
    chk("R9 pkt_valid", 64'(pkt_valid), 64'd0);
    chk("R9 xfer_valid", 64'(xfer_valid), 64'd0);
    chk("R9 pix_valid", 64'(pix_valid), 64'd0);
    for (int i = 0; i < N_ENV; i++)
      chk("R9 env reset", 64'(env_regs[32*i +: 32]), 64'((32'hE0 + i) << 24));
    @(negedge clk);
    rst_n = 1'b1;

    // R1 R2 R11: table of fixed lengths
    for (int v = 0; v < 24; v++) begin
      logic [7:0] op;
      int n;
      op = VEC[v][15:8];
      n  = int'(VEC[v][7:0]);
      push({op, 24'h00ABCD});
      for (int k = 1; k < n; k++) begin
        chk("R11 not early", 64'(pkt_valid), 64'd0);
        push(32'h0000_1000 + 32'(k));
      end
      chk(n == 1 ? "R2 valid" : "R1 valid", 64'(pkt_valid), 64'd1);
      chk(n == 1 ? "R2 len" : "R1 len", 64'(pkt_len), 64'(n));
      chk("R1 word0", 64'(pw(0)), 64'({op, 24'h00ABCD}));
      if (n > 1) chk("R1 last word", 64'(pw(n - 1)), 64'(32'h0000_1000 + 32'(n - 1)));
      pop();
      chk("R10 popped", 64'(pkt_valid), 64'd0);
    end

    // R3 unshaded: match at index 2 ignored, index 3 ends
    push(32'h4800_0000);
    push(32'h0000_0001);
    push(32'h5000_5000);
    chk("R3 idx2 ignored", 64'(pkt_valid), 64'd0);
    push(32'h5555_5555);
    chk("R3 valid", 64'(pkt_valid), 64'd1);
    chk("R3 len", 64'(pkt_len), 64'd4);
    chk("R3 more", 64'(pkt_more), 64'd0);
    chk("R3 term kept", 64'(pw(3)), 64'(32'h5555_5555));
    pop();

    // R4 shaded: odd indices ignored, even index 6 ends
    push(32'h5800_0000);
    push(32'h0000_0001);
    push(32'h0000_0002);
    push(32'h5000_5000);
    push(32'h0000_0004);
    push(32'h5000_5000);
    chk("R4 odd ignored", 64'(pkt_valid), 64'd0);
    push(32'h5FFF_5FFF);
    chk("R4 len", 64'(pkt_len), 64'd7);
    chk("R4 valid", 64'(pkt_valid), 64'd1);
    pop();

    // R5 unshaded chunking
    push(32'h4A00_0000);
    for (int k = 1; k < 16; k++) push(32'h0000_2000 + 32'(k));
    chk("R5 chunk valid", 64'(pkt_valid), 64'd1);
    chk("R5 chunk len", 64'(pkt_len), 64'd16);
    chk("R5 chunk more", 64'(pkt_more), 64'd1);
    pop();
    for (int k = 16; k < 20; k++) push(32'h0000_2000 + 32'(k));
    chk("R5 no early end", 64'(pkt_valid), 64'd0);
    push(32'h5000_5000);
    chk("R5 tail len", 64'(pkt_len), 64'd5);
    chk("R5 tail more", 64'(pkt_more), 64'd0);
    chk("R5 tail word0", 64'(pw(0)), 64'(32'h0000_2010));
    pop();

    // R5 + R4: shaded parity across a chunk
    push(32'h5C00_0000);
    for (int k = 1; k < 16; k++) push(32'h0000_3000 + 32'(k));
    chk("R5 shaded chunk more", 64'(pkt_more), 64'd1);
    pop();
    push(32'h0000_3010);
    push(32'h5000_5000);
    chk("R5 odd idx17 ignored", 64'(pkt_valid), 64'd0);
    push(32'h5000_5000);
    chk("R5 shaded tail len", 64'(pkt_len), 64'd3);
    chk("R5 shaded tail more", 64'(pkt_more), 64'd0);
    pop();

    // R6 R7 write transfer, 3x2 pixels -> 3 words
    push(32'hA000_0000);
    push(32'h0010_0020);
    push(32'h0002_0003);
    chk("R6 xfer pulse", 64'(xfer_valid), 64'd1);
    chk("R6 pos", 64'(xfer_pos), 64'(32'h0010_0020));
    chk("R6 size", 64'(xfer_size), 64'(32'h0002_0003));
    chk("R6 write dir", 64'(xfer_read), 64'd0);
    chk("R6 no packet", 64'(pkt_valid), 64'd0);
    push(32'hE512_3456);
    chk("R7 pix1 valid", 64'(pix_valid), 64'd1);
    chk("R7 pix1 data", 64'(pix_data), 64'(32'hE512_3456));
    chk("R6 pulse one cycle", 64'(xfer_valid), 64'd0);
    push(32'h2000_0000);
    chk("R7 pix2 data", 64'(pix_data), 64'(32'h2000_0000));
    push(32'h0100_0000);
    chk("R7 pix3 valid", 64'(pix_valid), 64'd1);
    chk("R7 no packet", 64'(pkt_valid), 64'd0);
    chk("R7 env untouched", 64'(env_regs[32*5 +: 32]), 64'(32'hE500_0000));
    push(32'h0100_0000);
    chk("R7 decode resumed", 64'(pkt_valid), 64'd1);
    chk("R7 pix stopped", 64'(pix_valid), 64'd0);
    pop();

    // R7 odd pixel count: 3x1 -> 2 words
    push(32'hBF00_0000);
    push(32'h0000_0000);
    push(32'h0001_0003);
    push(32'h1111_1111);
    push(32'h2222_2222);
    chk("R7 odd last pix", 64'(pix_valid), 64'd1);
    push(32'h0000_0000);
    chk("R7 odd resumed", 64'(pkt_valid), 64'd1);
    pop();

    // R6 read transfer: no diversion
    push(32'hC000_0000);
    push(32'h0001_0002);
    push(32'h0004_0004);
    chk("R6 read dir", 64'(xfer_read), 64'd1);
    push(32'h0100_0000);
    chk("R6 read no divert", 64'(pkt_valid), 64'd1);
    chk("R6 read no pix", 64'(pix_valid), 64'd0);
    pop();

    // R8 environment write
    push(32'hE3AB_CDEF);
    chk("R8 env3", 64'(env_regs[32*3 +: 32]), 64'(32'hE3AB_CDEF));
    chk("R8 env2 kept", 64'(env_regs[32*2 +: 32]), 64'(32'hE200_0000));
    chk("R8 forwarded", 64'(pkt_len), 64'd1);
    chk("R8 fwd word", 64'(pw(0)), 64'(32'hE3AB_CDEF));
    pop();

    // R10 backpressure
    push(32'h0100_0000);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = 32'h1F00_0000;
    for (int c = 0; c < 3; c++) begin
      @(posedge clk);
      #1;
      chk("R10 stall", 64'(in_ready), 64'd0);
      chk("R10 hold", 64'(pw(0)), 64'(32'h0100_0000));
    end
    @(negedge clk);
    pkt_ready = 1'b1;
    @(posedge clk);
    #1;
    pkt_ready = 1'b0;
    chk("R10 after pop", 64'(pkt_valid), 64'd0);
    @(posedge clk);
    #1;
    in_valid = 1'b0;
    chk("R10 held word taken", 64'(pw(0)), 64'(32'h1F00_0000));
    chk("R10 held word valid", 64'(pkt_valid), 64'd1);
    pop();

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule